// File: doc/BRIEF.md
# Iambic Morse Paddle Keyer

This block turns a two-lever Morse paddle into correctly timed elements on a key line, and adds a square-wave sidetone for monitoring. Holding the short-element lever sends a stream of dits. Holding the long-element lever sends a stream of dahs. Squeezing both levers sends alternating dits and dahs. If the opposite lever is touched at any time during an element or its trailing gap, that touch is latched. The latched touch then forces the next element to be the opposite type, even if the lever has been released by then.

Timing is based on a unit derived from the clock. A prescaler with a runtime reload value emits one tick per unit, so the sending speed can be changed without resynthesis. A dit is one unit of key-down and a dah is three. Each element is followed by one unit of key-up. Both paddle pins are active-low, so a grounded lever means pressed, and each pin is synchronized before use. The sidetone comes from a separate divider and is forced low whenever the key is up.

Top module: `paddle_keyer`

## Requirements
- R1: The paddle pins `dit_n`/`dah_n` are active-low (0 = pressed) and pass through a two-flop synchronizer. When the keyer is idle, `key_out` is still low two rising edges after a press is applied and goes high on the third rising edge.
- R2: One unit lasts `unit_reload`+1 clock cycles. While only the dit lever is held, every key-down period lasts exactly one unit and every key-up gap between elements lasts exactly one unit.
- R3: While only the dah lever is held, every key-down period lasts three units and every gap lasts one unit.
- R4: When both levers are pressed together from idle, the first element is a dit. While both stay held, the elements strictly alternate dit, dah, dit, dah.
- R5: A press of the opposite lever during an element is remembered, so the next element is of the opposite type even if that lever is released before the element ends. The memory is cleared when that element begins, so with no lever held afterwards nothing further is sent.
- R6: `tone_out` is low whenever `key_out` is low. While `key_out` is high, `tone_out` is a square wave whose high phases last `TONE_HALF` cycles each.
- R7: With no lever pressed, `key_out` stays low. After the last element's gap ends with no lever held, the keyer returns to idle.
- R8: A new `unit_reload` value applied while the keyer is idle sets the unit length of the next elements.
- R9: While `rst_n` is low, `key_out` and `tone_out` are low, even with a lever pressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dit_n | input | 1 | Short-element lever, active-low, asynchronous |
| dah_n | input | 1 | Long-element lever, active-low, asynchronous |
| unit_reload | input | SPEED_W | Prescaler reload; unit length is this value plus one cycles |
| key_out | output | 1 | Key line, high while an element is being sent |
| tone_out | output | 1 | Square-wave sidetone, low while the key is up |

## Verification
A wrong element-type flop shows on the key line as a mark of one unit where three were due, or the reverse, and the bench sees it when that key-down period ends. A lost or stuck memory flop shows one gap later: either an extra element is sent after the levers are released, or a squeezed pattern stops alternating. A miscounted prescaler or unit counter stretches or shortens every mark and gap, and measuring each run length in cycles exposes it on the very first element. A sidetone divider that is not cleared shows up as tone activity while the key is up, or as a wrong first high phase.

// File: rtl/keyer_pkg.sv
package keyer_pkg;
   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_MARK = 2'd1,
      KS_GAP  = 2'd2
   } key_state_t;

   localparam int DIT_UNITS = 1;
   localparam int DAH_UNITS = 3;
   localparam int GAP_UNITS = 1;
endpackage

// File: rtl/keyer_sync.sv
module keyer_sync #(
   parameter int N_BITS = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] async_in,
   output logic [N_BITS-1:0] sync_out
);
   logic [N_BITS-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/keyer_prescale.sv
module keyer_prescale #(
   parameter int SPEED_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SPEED_W-1:0] reload,
   output logic               tick
);
   logic [SPEED_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= reload;
      else if (cnt == '0)  cnt <= reload;
      else                 cnt <= cnt - 1'b1;
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/keyer_seq.sv
module keyer_seq
   import keyer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dit_on,
   input  logic dah_on,
   input  logic tick,
   output logic busy,
   output logic key,
   output logic gap_end,
   output logic elem_dah,
   output logic mem_q
);
   localparam logic [1:0] LAST_DIT = 2'(DIT_UNITS - 1);
   localparam logic [1:0] LAST_DAH = 2'(DAH_UNITS - 1);
   localparam logic [1:0] LAST_GAP = 2'(GAP_UNITS - 1);

   key_state_t state;
   logic [1:0] units;
   logic       opp_held;
   logic       same_held;
   logic [1:0] last_mark;

   assign opp_held  = elem_dah ? dit_on : dah_on;
   assign same_held = elem_dah ? dah_on : dit_on;
   assign last_mark = elem_dah ? LAST_DAH : LAST_DIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= KS_IDLE;
         units    <= '0;
         elem_dah <= 1'b0;
         mem_q    <= 1'b0;
      end else begin
         case (state)
            KS_IDLE: begin
               if (dit_on || dah_on) begin
                  state    <= KS_MARK;
                  elem_dah <= !dit_on;
                  units    <= '0;
                  mem_q    <= 1'b0;
               end
            end
            KS_MARK: begin
               if (opp_held) mem_q <= 1'b1;
               if (tick) begin
                  if (units == last_mark) begin
                     state <= KS_GAP;
                     units <= '0;
                  end else begin
                     units <= units + 1'b1;
                  end
               end
            end
            KS_GAP: begin
               if (opp_held) mem_q <= 1'b1;
               if (tick) begin
                  if (units != LAST_GAP) begin
                     units <= units + 1'b1;
                  end else begin
                     units <= '0;
                     if (mem_q || (opp_held && !same_held)) begin
                        state    <= KS_MARK;
                        elem_dah <= !elem_dah;
                        mem_q    <= 1'b0;
                     end else if (same_held) begin
                        state <= KS_MARK;
                        mem_q <= 1'b0;
                     end else begin
                        state <= KS_IDLE;
                        mem_q <= 1'b0;
                     end
                  end
               end
            end
            default: state <= KS_IDLE;
         endcase
      end
   end

   assign busy    = (state != KS_IDLE);
   assign key     = (state == KS_MARK);
   assign gap_end = (state == KS_GAP) && tick && (units == LAST_GAP);
endmodule

// File: rtl/keyer_tone.sv
module keyer_tone #(
   parameter int TONE_HALF = 31250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tone
);
   localparam int CW = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1;
   localparam logic [CW-1:0] WRAP = CW'(TONE_HALF - 1);

   logic [CW-1:0] cnt;
   logic          phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!en) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (cnt == WRAP) begin
         cnt   <= '0;
         phase <= !phase;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign tone = phase && en;
endmodule

// File: rtl/paddle_keyer.sv
module paddle_keyer #(
   parameter int SPEED_W      = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int TONE_HALF    = 31250,
   parameter bit TONE_ENABLE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dit_n,
   input  logic               dah_n,
   input  logic [SPEED_W-1:0] unit_reload,
   output logic               key_out,
   output logic               tone_out
);
   generate
      if (SPEED_W < 1) begin : g_bad_speed
         $error("paddle_keyer: SPEED_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("paddle_keyer: SYNC_STAGES must be at least 2");
      end
      if (TONE_HALF < 2) begin : g_bad_tone
         $error("paddle_keyer: TONE_HALF must be at least 2");
      end
   endgenerate

   logic [1:0] pad_raw;
   logic [1:0] pad_on;
   logic       busy;
   logic       unit_tick;
   logic       gap_end;
   logic       elem_dah;
   logic       mem_q;

   assign pad_raw = {!dah_n, !dit_n};

   keyer_sync #(.N_BITS(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_raw),
      .sync_out (pad_on)
   );

   keyer_prescale #(.SPEED_W(SPEED_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .reload (unit_reload),
      .tick   (unit_tick)
   );

   keyer_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dit_on   (pad_on[0]),
      .dah_on   (pad_on[1]),
      .tick     (unit_tick),
      .busy     (busy),
      .key      (key_out),
      .gap_end  (gap_end),
      .elem_dah (elem_dah),
      .mem_q    (mem_q)
   );

   generate
      if (TONE_ENABLE) begin : g_tone
         keyer_tone #(.TONE_HALF(TONE_HALF)) u_tone (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (key_out),
            .tone  (tone_out)
         );
      end else begin : g_no_tone
         assign tone_out = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/paddle_keyer_chk.sv
module paddle_keyer_chk (
   input logic clk,
   input logic rst_n,
   input logic key_out,
   input logic tone_out,
   input logic busy,
   input logic unit_tick,
   input logic gap_end,
   input logic elem_dah,
   input logic mem_q
);
   a_r6_tone_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !key_out |-> !tone_out);

   a_r2_key_moves_on_unit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !unit_tick) |=> $stable(key_out));

   a_r2_tick_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      unit_tick |-> busy);

   a_r7_idle_key_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !key_out);

   a_r5_memory_flips_type: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_end && mem_q) |=> (key_out && (elem_dah != $past(elem_dah)) && !mem_q));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r9_reset_quiet: assert (!key_out && !tone_out);
      end
   end
endmodule

bind paddle_keyer paddle_keyer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .key_out   (key_out),
   .tone_out  (tone_out),
   .busy      (busy),
   .unit_tick (unit_tick),
   .gap_end   (gap_end),
   .elem_dah  (elem_dah),
   .mem_q     (mem_q)
);

// File: tb/paddle_keyer_test.sv
module paddle_keyer_test;
   localparam int RW   = 16;
   localparam int HALF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dit_n = 1'b1;
   logic          dah_n = 1'b1;
   logic [RW-1:0] reload = 16'd19;
   logic          key_out;
   logic          tone_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   paddle_keyer #(.SPEED_W(RW), .TONE_HALF(HALF)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .dit_n       (dit_n),
      .dah_n       (dah_n),
      .unit_reload (reload),
      .key_out     (key_out),
      .tone_out    (tone_out)
   );

   // run-length monitor on the falling edge
   int marks[$];
   int gaps[$];
   int hi_run = 0;
   int lo_run = 0;
   int tone_run = 0;
   int tone_runs = 0;
   int tone_run_bad = 0;
   int tone_gate_bad = 0;
   int key_high_samples = 0;
   bit prev_key = 1'b0;
   bit prev_tone = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (key_out && !prev_key) begin
            if (marks.size() > 0) gaps.push_back(lo_run);
            hi_run = 0;
         end
         if (!key_out && prev_key) begin
            marks.push_back(hi_run);
            lo_run = 0;
         end
         if (key_out) begin
            hi_run++;
            key_high_samples++;
         end else begin
            lo_run++;
         end
         if (!key_out && tone_out) tone_gate_bad++;
         if (key_out && prev_tone && !tone_out) begin
            tone_runs++;
            if (tone_run != HALF) tone_run_bad++;
         end
         if (tone_out) tone_run++;
         else          tone_run = 0;
         prev_key  = key_out;
         prev_tone = tone_out;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int unit_len();
      return int'(reload) + 1;
   endfunction

   task automatic clear_log();
      @(posedge clk);
      marks.delete();
      gaps.delete();
      tone_runs = 0;
      tone_run_bad = 0;
      tone_gate_bad = 0;
      key_high_samples = 0;
   endtask

   task automatic wait_idle();
      repeat (12 * unit_len()) @(negedge clk);
   endtask

   task automatic check_all(input string req, input int mark_len, input int gap_len);
      for (int i = 0; i < marks.size(); i++)
         check(marks[i] == mark_len, req, marks[i], mark_len);
      for (int i = 0; i < gaps.size(); i++)
         check(gaps[i] == gap_len, req, gaps[i], gap_len);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      dit_n = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(key_out == 1'b0, "R9 key in reset", int'(key_out), 0);
         check(tone_out == 1'b0, "R9 tone in reset", int'(tone_out), 0);
      end
      dit_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(key_out == 1'b0, "R9 key after reset", int'(key_out), 0);
   endtask

   task automatic t_latency();
      clear_log();
      @(negedge clk);
      dit_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(key_out == 1'b0, "R1 key low after two edges", int'(key_out), 0);
      @(posedge clk);
      @(negedge clk);
      check(key_out == 1'b1, "R1 key high after three edges", int'(key_out), 1);
      dit_n = 1'b1;
      wait_idle();
      check(marks.size() == 1, "R1 single dit count", marks.size(), 1);
      check_all("R2 single dit length", unit_len(), unit_len());
   endtask

   task automatic t_no_press();
      clear_log();
      repeat (300) @(negedge clk);
      check(key_high_samples == 0, "R7 no key without paddle", key_high_samples, 0);
      check(marks.size() == 0, "R7 no elements", marks.size(), 0);
   endtask

   task automatic t_dit_hold();
      clear_log();
      @(negedge clk);
      dit_n = 1'b0;
      repeat (7 * unit_len()) @(negedge clk);
      dit_n = 1'b1;
      wait_idle();
      check(marks.size() >= 3, "R2 dit count", marks.size(), 3);
      check_all("R2 dit timing", unit_len(), unit_len());
      check(key_out == 1'b0, "R7 idle after release", int'(key_out), 0);
   endtask

   task automatic t_dah_hold();
      clear_log();
      @(negedge clk);
      dah_n = 1'b0;
      repeat (11 * unit_len()) @(negedge clk);
      dah_n = 1'b1;
      wait_idle();
      check(marks.size() >= 2, "R3 dah count", marks.size(), 2);
      check_all("R3 dah timing", 3 * unit_len(), unit_len());
   endtask

   task automatic t_squeeze();
      clear_log();
      @(negedge clk);
      dit_n = 1'b0;
      dah_n = 1'b0;
      repeat (13 * unit_len()) @(negedge clk);
      dit_n = 1'b1;
      dah_n = 1'b1;
      wait_idle();
      check(marks.size() >= 4, "R4 squeeze count", marks.size(), 4);
      for (int i = 0; i < marks.size(); i++) begin
         int exp_len;
         exp_len = (i % 2 == 0) ? unit_len() : 3 * unit_len();
         check(marks[i] == exp_len, "R4 alternation", marks[i], exp_len);
      end
      for (int i = 0; i < gaps.size(); i++)
         check(gaps[i] == unit_len(), "R4 gap", gaps[i], unit_len());
   endtask

   task automatic t_memory();
      clear_log();
      @(negedge clk);
      dit_n = 1'b0;
      while (!key_out) @(negedge clk);
      repeat (5) @(negedge clk);
      dah_n = 1'b0;
      repeat (4) @(negedge clk);
      dah_n = 1'b1;
      dit_n = 1'b1;
      wait_idle();
      check(marks.size() == 2, "R5 memory element count", marks.size(), 2);
      if (marks.size() >= 2) begin
         check(marks[0] == unit_len(), "R5 first is dit", marks[0], unit_len());
         check(marks[1] == 3 * unit_len(), "R5 remembered dah", marks[1], 3 * unit_len());
      end
      if (gaps.size() >= 1)
         check(gaps[0] == unit_len(), "R5 gap", gaps[0], unit_len());
   endtask

   task automatic t_speed();
      reload = 16'd9;
      clear_log();
      @(negedge clk);
      dit_n = 1'b0;
      repeat (7 * unit_len()) @(negedge clk);
      dit_n = 1'b1;
      wait_idle();
      check(marks.size() >= 3, "R8 fast dit count", marks.size(), 3);
      check_all("R8 fast dit timing", 10, 10);
      reload = 16'd19;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_tone();
      clear_log();
      @(negedge clk);
      dah_n = 1'b0;
      repeat (9 * unit_len()) @(negedge clk);
      dah_n = 1'b1;
      wait_idle();
      check(tone_runs > 0, "R6 tone toggles", tone_runs, 1);
      check(tone_run_bad == 0, "R6 tone high phase length", tone_run_bad, 0);
      check(tone_gate_bad == 0, "R6 tone gated with key", tone_gate_bad, 0);
      check(tone_out == 1'b0, "R6 tone low when idle", int'(tone_out), 0);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_no_press();
      t_dit_hold();
      t_dah_hold();
      t_squeeze();
      t_memory();
      t_speed();
      t_tone();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule